// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two N-bit unsigned words with a single full adder, one bit per clock. Each operand sits in its own register. The register can either take a whole word in one cycle or move right by one place. A load pulse captures both words and clears the stored carry. A start pulse then runs exactly N add cycles.

In every add cycle the full adder combines the lowest bit of each operand register with the stored carry. The carry-out goes back into the carry flip-flop. The sum bit enters the top of the first operand register as that register moves right. The second operand register fills with zeros from its top.

After N cycles the first operand register holds the sum, the flip-flop holds the carry out of the top bit, and a one-cycle completion pulse is raised. The result is visible at all times, so partial sums can be seen while the addition runs.

Top module: `bitser_adder`

## Requirements
- R1: While reset is asserted and after it is released, `sum_o` is 0, `carry_o` is 0 and `done_o` is 0.
- R2: A cycle with `load_i` high copies `a_i` into the result register (seen on `sum_o` after that edge), copies `b_i` into the second operand register and clears `carry_o` to 0.
- R3: After a load and an accepted start, `sum_o` equals (a + b) mod 2^N and `carry_o` equals bit N of a + b once the operation completes.
- R4: `done_o` rises N clock edges after the edge that accepts a start, together with the final result, and stays high for exactly one cycle.
- R5: While no operation runs and neither `load_i` nor `start_i` is high, `sum_o` and `carry_o` keep their values.
- R6: A start pulse that arrives while an operation runs is ignored: the completion time and the result are unchanged.
- R7: When `load_i` and `start_i` are high in the same cycle, the load takes effect and no operation starts: `sum_o` shows the new operand and `done_o` stays low.
- R8: A load during a running operation aborts it: the new operands are taken, the carry is cleared, and no `done_o` pulse follows.
- R9: During each add cycle the result register moves right by one place. The new sum bit enters bit N-1, so after the first add cycle `sum_o` = {a[0]^b[0], a[N-1:1]}.
- R10: A second start without a reload adds the stored carry to the result, because the second operand has been shifted to zero. The new result is (s + c) mod 2^N, with the carry out in `carry_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Capture both operands and clear the carry |
| start_i | input | 1 | Begin an N-cycle serial addition when idle |
| a_i | input | N | First operand, also the destination of the sum |
| b_i | input | N | Second operand |
| sum_o | output | N | Contents of the result register |
| carry_o | output | 1 | Stored carry; final carry out after completion |
| done_o | output | 1 | One-cycle pulse when the addition finishes |

## Verification
A load can coincide with a start, or with any cycle of a running addition, including the last one. The bench forces both collisions. It raises load and start in the same cycle, and it asserts load two cycles into a run. In both cases the register contents must be the freshly loaded words with a cleared carry, and the completion pulse must never appear. A later normal run on the new operands then confirms that the control logic has returned cleanly to idle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    BSA_IDLE = 1'b0,
    BSA_RUN  = 1'b1
  } bsa_phase_t;

  function automatic int bsa_cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bsa_opreg.sv
module bsa_opreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         shift_en,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  // Next state: load wins over shift, otherwise hold
  always_comb begin
    q_d = q_q;
    if (load_en) begin
      q_d = par_i;
    end else if (shift_en) begin
      q_d = {ser_i, q_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/bsa_fa.sv
module bsa_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic prop;

  assign prop = x_i ^ y_i;
  assign s_o  = prop ^ c_i;
  assign c_o  = (x_i & y_i) | (prop & c_i);

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic start_i,
  output logic busy_o,
  output logic shift_en_o,
  output logic done_o
);

  localparam int CW = bsa_cnt_w(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  bsa_phase_t    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (load_i) begin
      phase_d = BSA_IDLE;
      cnt_d   = '0;
    end else if (phase_q == BSA_IDLE) begin
      if (start_i) begin
        phase_d = BSA_RUN;
        cnt_d   = '0;
      end
    end else begin
      if (cnt_q == LAST) begin
        phase_d = BSA_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= BSA_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o     = (phase_q == BSA_RUN);
  assign shift_en_o = (phase_q == BSA_RUN) && !load_i;
  assign done_o     = done_q;

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         start_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o,
  output logic         carry_o,
  output logic         done_o
);

  logic [N-1:0] acc_q;
  logic [N-1:0] addend_q;
  logic         run_busy;
  logic         step_en;
  logic         fa_sum;
  logic         fa_cout;
  logic         cy_q, cy_d;

  bsa_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .start_i    (start_i),
    .busy_o     (run_busy),
    .shift_en_o (step_en),
    .done_o     (done_o)
  );

  // Result/first operand: the sum bit enters at the top
  bsa_opreg #(.W(N)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_i),
    .shift_en (step_en),
    .par_i    (a_i),
    .ser_i    (fa_sum),
    .q_o      (acc_q)
  );

  // Second operand: zeros enter at the top
  bsa_opreg #(.W(N)) u_addend (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_i),
    .shift_en (step_en),
    .par_i    (b_i),
    .ser_i    (1'b0),
    .q_o      (addend_q)
  );

  bsa_fa u_fa (
    .x_i (acc_q[0]),
    .y_i (addend_q[0]),
    .c_i (cy_q),
    .s_o (fa_sum),
    .c_o (fa_cout)
  );

  always_comb begin
    cy_d = cy_q;
    if (load_i) begin
      cy_d = 1'b0;
    end else if (step_en) begin
      cy_d = fa_cout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
    end else begin
      cy_q <= cy_d;
    end
  end

  assign sum_o   = acc_q;
  assign carry_o = cy_q;

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic         start_i,
  input logic         busy,
  input logic         done_o,
  input logic         carry_o,
  input logic [N-1:0] sum_o
);

  localparam int LW = $clog2(N + 2) + 1;

  logic [LW-1:0] run_len;

  // Counts the add cycles since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (start_i && !busy && !load_i) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + 1'b1;
    end
  end

  AST_LOAD_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !carry_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_DONE_AFTER_N: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == LW'(N))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load_i && !start_i) |=> ($stable(sum_o) && $stable(carry_o))); // R5
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !load_i) |=> busy); // R3
  AST_LOAD_START_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && start_i) |=> (!busy && !done_o)); // R7
  AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_i) |=> (!busy && !done_o)); // R8

endmodule

bind bitser_adder bsa_checker #(.N(N)) u_bsa_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_i),
  .start_i (start_i),
  .busy    (run_busy),
  .done_o  (done_o),
  .carry_o (carry_o),
  .sum_o   (sum_o)
);

// File: tb/tb_bitser_adder.sv
`timescale 1ns/1ps
module tb_bitser_adder;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic         load_i;
  logic         start_i;
  logic [N-1:0] a_i;
  logic [N-1:0] b_i;
  logic [N-1:0] sum_o;
  logic         carry_o;
  logic         done_o;

  int checks;
  int errors;

  bitser_adder #(.N(N)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    load_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk);
    load_i = 1'b0;
    chk(32'(sum_o), 32'(a), "R2 operand loaded");
    chk(32'(carry_o), 0, "R2 carry cleared");
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Runs N cycles after start and checks done timing
  task automatic run_and_wait(input string tag);
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      chk(32'(done_o), (k == N) ? 1 : 0, {tag, " R4 done timing"});
    end
  endtask

  task automatic t_reset();
    chk(32'(sum_o), 0, "R1 sum after reset");
    chk(32'(carry_o), 0, "R1 carry after reset");
    chk(32'(done_o), 0, "R1 done after reset");
  endtask

  task automatic t_add(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] full;
    full = {1'b0, a} + {1'b0, b};
    do_load(a, b);
    pulse_start();
    run_and_wait("R3");
    chk(32'(sum_o), 32'(full[N-1:0]), "R3 sum");
    chk(32'(carry_o), 32'(full[N]), "R3 carry");
    @(negedge clk);
    chk(32'(done_o), 0, "R4 done one cycle");
    repeat (3) @(negedge clk);
    chk(32'(sum_o), 32'(full[N-1:0]), "R5 sum held while idle");
    chk(32'(carry_o), 32'(full[N]), "R5 carry held while idle");
  endtask

  task automatic t_first_step();
    logic [N-1:0] a, b;
    a = 4'b1011; b = 4'b0110;
    do_load(a, b);
    pulse_start();
    @(negedge clk);
    chk(32'(sum_o), 32'({a[0] ^ b[0], a[N-1:1]}), "R9 first shift");
    repeat (N) @(negedge clk);
  endtask

  task automatic t_start_busy();
    logic [N:0] full;
    full = 5'(4'd9) + 5'(4'd5);
    do_load(4'd9, 4'd5);
    pulse_start();
    @(negedge clk);
    pulse_start();
    for (int k = 3; k <= N; k++) begin
      @(negedge clk);
      chk(32'(done_o), (k == N) ? 1 : 0, "R6 done timing unchanged");
    end
    chk(32'(sum_o), 32'(full[N-1:0]), "R6 sum unchanged");
    chk(32'(carry_o), 32'(full[N]), "R6 carry unchanged");
    repeat (N + 1) begin
      @(negedge clk);
      chk(32'(done_o), 0, "R6 no extra run");
    end
  endtask

  task automatic t_load_start_clash();
    do_load(4'd3, 4'd3);
    @(negedge clk);
    load_i = 1'b1; start_i = 1'b1; a_i = 4'd12; b_i = 4'd7;
    @(negedge clk);
    load_i = 1'b0; start_i = 1'b0;
    chk(32'(sum_o), 12, "R7 load wins");
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      chk(32'(done_o), 0, "R7 no done");
    end
    chk(32'(sum_o), 12, "R7 no addition ran");
  endtask

  task automatic t_abort();
    do_load(4'hF, 4'hF);
    pulse_start();
    repeat (2) @(negedge clk);
    load_i = 1'b1; a_i = 4'd2; b_i = 4'd1;
    @(negedge clk);
    load_i = 1'b0;
    chk(32'(sum_o), 2, "R8 new operand");
    chk(32'(carry_o), 0, "R8 carry cleared");
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk);
      chk(32'(done_o), 0, "R8 no done after abort");
    end
    pulse_start();
    run_and_wait("R8");
    chk(32'(sum_o), 3, "R8 fresh run sum");
    chk(32'(carry_o), 0, "R8 fresh run carry");
  endtask

  task automatic t_restart_carry();
    logic [N:0] nxt;
    do_load(4'hF, 4'h1);
    pulse_start();
    run_and_wait("R10 first");
    chk(32'(sum_o), 0, "R10 first sum");
    chk(32'(carry_o), 1, "R10 first carry");
    nxt = {1'b0, sum_o} + (N+1)'(carry_o);
    @(negedge clk);
    pulse_start();
    run_and_wait("R10 second");
    chk(32'(sum_o), 32'(nxt[N-1:0]), "R10 carry added");
    chk(32'(carry_o), 32'(nxt[N]), "R10 carry out");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; load_i = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add(4'd3, 4'd4);
    t_add(4'd7, 4'd9);
    t_add(4'hF, 4'hF);
    t_add(4'd0, 4'd0);
    t_add(4'b1010, 4'b0101);
    t_first_step();
    t_start_busy();
    t_load_start_clash();
    t_abort();
    t_restart_carry();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule